// File: doc/BRIEF.md
# Two-Way Sorted Stream Merger

This block combines two sequences, each already in ascending key order, into a single ascending output stream. Both sequences arrive on one shared input channel. A sideband select bit on every beat says which sequence the word belongs to. A steering stage writes the word into that sequence's queue. Both queues are deep and built in block memory, so thousands of words can wait in them.

A merge engine keeps one head word per sequence. On each step it compares the keys of the two heads, moves the smaller one into a small output queue, and then refills only the head it used. A word carries a key in its upper bits and a free payload in its lower bits. When the keys are equal, the word from the first sequence goes out first, so the merge is stable. Each sequence ends with a flagged final word. When one sequence has ended, the engine passes the rest of the other sequence straight through. When a sequence has not ended but its queue is empty, the engine waits for that sequence's next word.

A downstream consumer drains the output through a valid/ready handshake. A one-cycle completion pulse marks the end of each pair of sequences. The engine then starts on the next pair, whose words may already be waiting in the queues.

Top module: `stream_merge2`

## Requirements
- R1: A beat with `in_sel`=0 goes to the first sequence's queue and a beat with `in_sel`=1 goes to the second. `in_ready` reflects only the fullness of the queue that `in_sel` selects.
- R2: Output words of one pair come out in non-decreasing order of key, where the key is the upper KEY_W bits of the word. The lower bits are carried through unchanged.
- R3: When the two head keys are equal, the word from the first sequence (`in_sel`=0) is emitted before the word from the second.
- R4: Once a sequence's final word (`in_last`=1) has been emitted, the remaining words of the other sequence are emitted in arrival order, with no wait for further input on the finished sequence.
- R5: While a sequence has not delivered its final word and its queue is empty, no output word is emitted, even if the other head is available.
- R6: While `out_ready` is low, `out_valid` stays high and `out_data` stays stable. No word is lost or duplicated across back-pressure.
- R7: `in_ready` falls when the selected queue is full. A stalled sequence absorbs LIST_DEPTH words plus one held head word.
- R8: `done` is high for exactly one cycle per pair, after the final word of both sequences has entered the output queue.
- R9: Words of a following pair that arrive before the current pair completes are not merged into the current pair.
- R10: After reset, `out_valid` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Selected queue can accept the beat |
| in_sel | input | 1 | Sequence select: 0 first, 1 second |
| in_last | input | 1 | Final word of the selected sequence |
| in_data | input | DATA_W | Word, key in the upper KEY_W bits |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Merged output word |
| done | output | 1 | One-cycle pulse at completion of a pair |

## Verification
The assertions assume that the producer holds each sequence in ascending key order and marks exactly one final word per sequence in each pair. They also assume that input beats keep their select bit and data steady while `in_ready` is low. The stimulus builds every sequence with rising keys and a single final flag per pair, and drives each beat until a handshake completes. Ties, early arrival of the next pair, full queues and a stalled consumer are each reached with a directed sequence of their own.

// File: rtl/merge_pkg.sv
package merge_pkg;
  localparam int NUM_LISTS = 2;
  typedef enum logic {LIST_A = 1'b0, LIST_B = 1'b1} list_e;
endpackage

// File: rtl/merge_bram_fifo.sv
module merge_bram_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
    if (rd_en) rd_data <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (rd_en) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty);
endmodule

// File: rtl/merge_reg_fifo.sv
module merge_reg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign rd_data = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (rd_en) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty);
endmodule

// File: rtl/merge_engine.sv
module merge_engine
  import merge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int KEY_W  = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_LISTS-1:0]              q_empty,
  output logic [NUM_LISTS-1:0]              q_rd,
  input  logic [NUM_LISTS-1:0][DATA_W:0]    q_data,
  input  logic                              o_full,
  output logic                              o_push,
  output logic [DATA_W-1:0]                 o_data,
  output logic                              done
);
  localparam int FW = DATA_W + 1;

  logic [NUM_LISTS-1:0]          fetch_q, hvalid_q, hv, avail, exh_q, take;
  logic [NUM_LISTS-1:0][FW-1:0]  hreg_q, hd;
  logic [NUM_LISTS-1:0][KEY_W-1:0] key;
  list_e                         pick;
  logic                          pick_last;
  logic                          done_q;

  // Per-list head tracking: one word held, refilled when taken.
  for (genvar g = 0; g < NUM_LISTS; g++) begin : g_head
    assign hv[g]    = hvalid_q[g] | fetch_q[g];
    assign hd[g]    = fetch_q[g] ? q_data[g] : hreg_q[g];
    assign key[g]   = hd[g][DATA_W-1 -: KEY_W];
    assign avail[g] = hv[g] & ~exh_q[g];
    assign q_rd[g]  = ~q_empty[g] & (~hv[g] | take[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        fetch_q[g]  <= 1'b0;
        hvalid_q[g] <= 1'b0;
        hreg_q[g]   <= '0;
      end else begin
        fetch_q[g] <= q_rd[g];
        if (take[g]) begin
          hvalid_q[g] <= 1'b0;
        end else if (fetch_q[g]) begin
          hvalid_q[g] <= 1'b1;
          hreg_q[g]   <= q_data[g];
        end
      end
    end
  end

  // One comparison per output word; ties favour the first list.
  always_comb begin
    take = '0;
    if (!o_full) begin
      if (avail[0] && avail[1])       take = (key[0] <= key[1]) ? 2'b01 : 2'b10;
      else if (avail[0] && exh_q[1])  take = 2'b01;
      else if (avail[1] && exh_q[0])  take = 2'b10;
    end
  end

  assign pick      = take[1] ? LIST_B : LIST_A;
  assign o_push    = |take;
  assign o_data    = hd[pick][DATA_W-1:0];
  assign pick_last = hd[pick][DATA_W];
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exh_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (o_push && pick_last) begin
        if (exh_q[~pick]) begin
          exh_q  <= '0;
          done_q <= 1'b1;
        end else begin
          exh_q[pick] <= 1'b1;
        end
      end
    end
  end

  a_r2_single_take: assert property (@(posedge clk) disable iff (rst) $onehot0(take));
  a_r6_push_room: assert property (@(posedge clk) disable iff (rst) o_push |-> !o_full);
  a_r5_wait_a: assert property (@(posedge clk) disable iff (rst) (!hv[0] && !exh_q[0]) |-> !o_push);
  a_r5_wait_b: assert property (@(posedge clk) disable iff (rst) (!hv[1] && !exh_q[1]) |-> !o_push);
  a_r3_tie_first: assert property (@(posedge clk) disable iff (rst)
    (avail[0] && avail[1] && key[0] == key[1] && !o_full) |-> (o_push && pick == LIST_A));
  a_r9_no_cross: assert property (@(posedge clk) disable iff (rst)
    (o_push && exh_q[pick]) |-> 1'b0);
endmodule

// File: rtl/stream_merge2.sv
module stream_merge2
  import merge_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int KEY_W      = 12,
  parameter int LIST_DEPTH = 1024,
  parameter int OUT_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sel,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  localparam int FW = DATA_W + 1;

  logic [NUM_LISTS-1:0]         q_wr, q_rd, q_empty, q_full;
  logic [NUM_LISTS-1:0][FW-1:0] q_data;
  logic                         o_push, o_full, o_empty, o_pop;
  logic [DATA_W-1:0]            o_wdata;

  assign in_ready = in_sel ? ~q_full[1] : ~q_full[0];

  for (genvar g = 0; g < NUM_LISTS; g++) begin : g_list
    assign q_wr[g] = in_valid & (in_sel == g[0]) & ~q_full[g];

    merge_bram_fifo #(.W(FW), .DEPTH(LIST_DEPTH)) u_q (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (q_wr[g]),
      .wr_data ({in_last, in_data}),
      .rd_en   (q_rd[g]),
      .rd_data (q_data[g]),
      .empty   (q_empty[g]),
      .full    (q_full[g])
    );
  end

  merge_engine #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .q_empty (q_empty),
    .q_rd    (q_rd),
    .q_data  (q_data),
    .o_full  (o_full),
    .o_push  (o_push),
    .o_data  (o_wdata),
    .done    (done)
  );

  assign out_valid = ~o_empty;
  assign o_pop     = out_valid & out_ready;

  merge_reg_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (o_push),
    .wr_data (o_wdata),
    .rd_en   (o_pop),
    .rd_data (out_data),
    .empty   (o_empty),
    .full    (o_full)
  );

  a_r6_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r1_steer_a: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_sel) |-> (q_wr[0] && !q_wr[1]));
  a_r1_steer_b: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sel) |-> (q_wr[1] && !q_wr[0]));
endmodule

// File: tb/stream_merge2_test.sv
module stream_merge2_test;
  localparam int DW = 16;
  localparam int LD = 1024;
  localparam int NV = 9;

  // {sel, last, key[11:0], tag[3:0]}
  localparam logic [17:0] IN_VEC [NV] = '{
    {1'b0, 1'b0, 12'd1,  4'hA}, {1'b1, 1'b0, 12'd2,  4'hB},
    {1'b0, 1'b0, 12'd3,  4'hA}, {1'b0, 1'b0, 12'd3,  4'hA},
    {1'b1, 1'b0, 12'd3,  4'hB}, {1'b0, 1'b0, 12'd7,  4'hA},
    {1'b1, 1'b0, 12'd8,  4'hB}, {1'b0, 1'b1, 12'd9,  4'hA},
    {1'b1, 1'b1, 12'd20, 4'hB}
  };
  localparam logic [15:0] EXP_VEC [NV] = '{
    {12'd1, 4'hA}, {12'd2, 4'hB}, {12'd3, 4'hA}, {12'd3, 4'hA}, {12'd3, 4'hB},
    {12'd7, 4'hA}, {12'd8, 4'hB}, {12'd9, 4'hA}, {12'd20, 4'hB}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sel = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  int rmode = 0, cap_n = 0, done_n = 0;
  logic [DW-1:0] cap [1100];

  always #5 clk = ~clk;

  stream_merge2 #(.DATA_W(DW), .KEY_W(12), .LIST_DEPTH(LD), .OUT_DEPTH(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sel(in_sel),
    .in_last(in_last), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  // Consumer model and done counter
  always @(negedge clk) begin
    case (rmode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'b0;
      default: out_ready = ~out_ready;
    endcase
    if (!rst && out_valid && out_ready) begin
      cap[cap_n] = out_data;
      cap_n++;
    end
    if (!rst && done) done_n++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic s, input logic l, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_sel = s; in_last = l; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    for (int t = 0; t < 4000 && cap_n < n; t++) @(negedge clk);
  endtask

  task automatic wait_done(input int n);
    for (int t = 0; t < 4000 && done_n < n; t++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R10 done after reset", int'(done), 0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    rst = 1'b0;

    // Table walk: R2 ordering, R3 tie, R4 drain, R8 one pulse
    cap_n = 0; done_n = 0;
    for (int i = 0; i < NV; i++) send(IN_VEC[i][17], IN_VEC[i][16], IN_VEC[i][15:0]);
    idle();
    wait_done(1);
    wait_caps(NV);
    repeat (5) @(negedge clk);
    chk(cap_n == NV, "R2 table word count", cap_n, NV);
    for (int i = 0; i < NV; i++)
      chk(cap[i] == EXP_VEC[i], "R2/R3/R4 table merged word", int'(cap[i]), int'(EXP_VEC[i]));
    chk(done_n == 1, "R8 one done pulse per pair", done_n, 1);

    // R5: first list complete, second empty -> nothing emitted
    cap_n = 0; done_n = 0;
    send(1'b0, 1'b0, {12'd5, 4'hA});
    send(1'b0, 1'b1, {12'd6, 4'hA});
    idle();
    repeat (30) @(negedge clk);
    chk(cap_n == 0, "R5 stall on empty unfinished list", cap_n, 0);
    chk(done_n == 0, "R8 no done before pair ends", done_n, 0);
    send(1'b1, 1'b1, {12'd1, 4'hB});
    idle();
    wait_done(1); wait_caps(3);
    chk(cap[0] == {12'd1, 4'hB}, "R5 first word after release", int'(cap[0]), int'({12'd1, 4'hB}));
    chk(cap[1] == {12'd5, 4'hA} && cap[2] == {12'd6, 4'hA}, "R4 drain remainder",
        int'({cap[1], cap[2]}), int'({12'd5, 4'hA, 12'd6, 4'hA}));

    // R6: output back-pressure
    cap_n = 0; done_n = 0; rmode = 1;
    send(1'b0, 1'b0, {12'd10, 4'hA});
    send(1'b1, 1'b0, {12'd20, 4'hB});
    send(1'b0, 1'b1, {12'd30, 4'hA});
    send(1'b1, 1'b1, {12'd40, 4'hB});
    idle();
    repeat (20) @(negedge clk);
    chk(cap_n == 0 && out_valid, "R6 valid held under back-pressure", cap_n, 0);
    chk(out_data == {12'd10, 4'hA}, "R6 data held under back-pressure",
        int'(out_data), int'({12'd10, 4'hA}));
    rmode = 2;
    wait_caps(4);
    repeat (6) @(negedge clk);
    rmode = 0;
    chk(cap_n == 4, "R6 no loss or duplication", cap_n, 4);
    chk(cap[0] == {12'd10, 4'hA} && cap[1] == {12'd20, 4'hB} &&
        cap[2] == {12'd30, 4'hA} && cap[3] == {12'd40, 4'hB}, "R6 order after back-pressure",
        int'(cap[3]), int'({12'd40, 4'hB}));
    chk(done_n == 1, "R8 done after back-pressure pair", done_n, 1);

    // R9: next pair arrives early on the first list
    cap_n = 0; done_n = 0;
    send(1'b0, 1'b1, {12'd50, 4'hA});
    send(1'b0, 1'b0, {12'd1, 4'h1});
    send(1'b0, 1'b1, {12'd2, 4'h1});
    send(1'b1, 1'b1, {12'd60, 4'hB});
    send(1'b1, 1'b1, {12'd3, 4'h2});
    idle();
    wait_done(2); wait_caps(5);
    repeat (3) @(negedge clk);
    chk(cap_n == 5, "R9 word count over two pairs", cap_n, 5);
    chk(cap[0] == {12'd50, 4'hA} && cap[1] == {12'd60, 4'hB}, "R9 first pair isolated",
        int'(cap[1]), int'({12'd60, 4'hB}));
    chk(cap[2] == {12'd1, 4'h1} && cap[3] == {12'd2, 4'h1} && cap[4] == {12'd3, 4'h2},
        "R9 second pair merged", int'(cap[4]), int'({12'd3, 4'h2}));
    chk(done_n == 2, "R8 one pulse per pair", done_n, 2);

    // R7/R1: fill first list queue while second is empty
    cap_n = 0; done_n = 0;
    for (int i = 0; i <= LD; i++) send(1'b0, (i == LD), {12'(i), 4'hA});
    @(negedge clk);
    in_valid = 1'b1; in_sel = 1'b0; #1;
    chk(in_ready == 1'b0, "R7 in_ready low on full queue", int'(in_ready), 0);
    in_sel = 1'b1; #1;
    chk(in_ready == 1'b1, "R1 other queue still ready", int'(in_ready), 1);
    in_valid = 1'b0;
    send(1'b1, 1'b1, {12'd4095, 4'hB});
    idle();
    wait_done(1); wait_caps(LD + 2);
    repeat (3) @(negedge clk);
    chk(cap_n == LD + 2, "R7 capacity LIST_DEPTH plus head", cap_n, LD + 2);
    begin
      int bad = 0;
      for (int i = 0; i <= LD; i++) if (cap[i] != {12'(i), 4'hA}) bad++;
      chk(bad == 0, "R2 long run ascending", bad, 0);
    end
    chk(cap[LD + 1] == {12'd4095, 4'hB}, "R4 final word", int'(cap[LD + 1]), int'({12'd4095, 4'hB}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule